// File: doc/BRIEF.md
# LPC Byte-Burst Sequencer

This block sits between a host register bus and a downstream LPC cycle engine. Software sets up a burst by writing four things: a byte-cycle count, a command word that picks the direction and the address mode, a 16-bit port address and, for writes, the payload bytes. The payload bytes go into a 16-entry write queue. A single start write then launches the whole burst. The sequencer hands the engine one byte request at a time. It holds each request until the engine answers with done or error. On reads, the returned bytes go into a 16-entry read queue, which software drains one byte per read of the read-data register.

A status word reports two separate flags: idle, and whether the last burst finished successfully. If the controller is idle and the success flag is clear, the last burst failed or was rejected. Every burst end sets a write-one-to-clear completion bit, and that bit can raise an interrupt. The pin-level protocol, address translation and DMA are handled elsewhere.

Register offsets: start 0x00, status 0x04, interrupt 0x08, length 0x10, command 0x14, address 0x20, write data 0x24, read data 0x28. Bus reads are combinational from `bus_addr`. A read of the read-data offset pops the queue at the next clock edge.

Top module: `lpc_burst_seq`

## Requirements
- R1: After reset, status reads idle=1 (bit 0) and finished=0 (bit 1), `eng_req` is low and `irq` is low.
- R2: In a write burst (command bit 0 = 1), the engine receives the queued bytes on `eng_wdata` in the order they were written to offset 0x24, one request per byte, and each request is held until `eng_done` or `eng_err`.
- R3: With command bit 3 = 0, the first request uses the programmed address and each later request uses the previous address plus one.
- R4: With command bit 3 = 1, every request in the burst uses the programmed address.
- R5: In a read burst (command bit 0 = 0), the bytes returned on `eng_rdata` are read back from offset 0x28 in arrival order. A read of an empty queue returns 0x00.
- R6: While a request is outstanding, status bit 0 is 0. After a burst in which every request got `eng_done`, status reads idle=1 and finished=1.
- R7: A start with length 0 or a length above 16 issues no request and leaves status at idle=1, finished=0.
- R8: `eng_err` aborts the burst. `eng_req` drops on the next cycle, no further requests are issued, and status reads idle=1, finished=0.
- R9: A start written while a burst is running has no effect. The running burst issues exactly its original count of requests.
- R10: Every burst end sets interrupt-register bit 1. Writing 1 to that bit clears it. `irq` is high exactly when enable (bit 0) and bit 1 are both set.
- R11: A write to offset 0x24 while the write queue holds 16 bytes is dropped. A write request issued with an empty queue carries 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops read queue at 0x28) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| eng_req | output | 1 | Byte cycle request to engine |
| eng_write | output | 1 | Request direction, 1 = write |
| eng_addr | output | 16 | Port address of current request |
| eng_wdata | output | 8 | Byte to write |
| eng_done | input | 1 | Engine completed current byte |
| eng_err | input | 1 | Engine failed current byte |
| eng_rdata | input | 8 | Byte read by engine, valid with eng_done |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest cases to reach from the ports are a start that lands in the middle of a burst and an engine error part-way through a burst. The bench's engine model answers each request only after a programmable number of wait cycles. This stretches a burst long enough for the second start, which comes with a larger length, to arrive while requests are still outstanding. The same model can raise an error on a chosen request index, which aborts a read burst after a known number of bytes. The surviving bytes are then drained from the read queue. A further pass overfills the write queue and then runs a one-byte write to show that the dropped byte never reached the queue.

// File: rtl/lpc_seq_pkg.sv
package lpc_seq_pkg;

    localparam int unsigned MAX_BURST = 16;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned PORT_W    = 16;

    localparam logic [7:0] OFF_START = 8'h00;
    localparam logic [7:0] OFF_STAT  = 8'h04;
    localparam logic [7:0] OFF_IRQ   = 8'h08;
    localparam logic [7:0] OFF_LEN   = 8'h10;
    localparam logic [7:0] OFF_CMD   = 8'h14;
    localparam logic [7:0] OFF_ADDR  = 8'h20;
    localparam logic [7:0] OFF_WDAT  = 8'h24;
    localparam logic [7:0] OFF_RDAT  = 8'h28;

    localparam int unsigned CMD_WR_BIT  = 0;
    localparam int unsigned CMD_FIX_BIT = 3;

    typedef enum logic [0:0] {SQ_IDLE, SQ_BUSY} sq_state_e;

    typedef struct packed {
        logic              write;
        logic              fixed;
        logic [PORT_W-1:0] addr;
        logic [7:0]        len;
    } burst_cfg_t;

    function automatic logic len_ok(input logic [7:0] len);
        return (len != 8'd0) && (len <= 8'(MAX_BURST));
    endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = PW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            if (do_push && !do_pop)      cnt <= cnt + CW'(1);
            else if (do_pop && !do_push) cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import lpc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  burst_cfg_t        cfg,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic              eng_req,
    output logic              eng_write,
    output logic [PORT_W-1:0] eng_addr,
    output logic              busy,
    output logic              fixed_mode,
    output logic              finished,
    output logic              end_evt,
    output logic              wq_pop,
    output logic              rq_push
);
    sq_state_e   state;
    burst_cfg_t  cur;
    logic        ok_byte;
    logic        last;

    assign busy       = (state == SQ_BUSY);
    assign eng_req    = busy;
    assign eng_write  = cur.write;
    assign eng_addr   = cur.addr;
    assign fixed_mode = cur.fixed;
    assign ok_byte    = busy && eng_done && !eng_err;
    assign last       = (cur.len == 8'd1);
    assign wq_pop     = ok_byte && cur.write;
    assign rq_push    = ok_byte && !cur.write;
    assign end_evt    = (!busy && start && !len_ok(cfg.len))
                      || (busy && eng_err)
                      || (ok_byte && last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cur      <= '0;
            finished <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: if (start) begin
                    finished <= 1'b0;
                    if (len_ok(cfg.len)) begin
                        cur   <= cfg;
                        state <= SQ_BUSY;
                    end
                end
                SQ_BUSY: begin
                    if (eng_err) begin
                        state <= SQ_IDLE;
                    end else if (eng_done) begin
                        cur.len <= cur.len - 8'd1;
                        if (!cur.fixed) cur.addr <= cur.addr + PORT_W'(1);
                        if (last) begin
                            state    <= SQ_IDLE;
                            finished <= 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpc_burst_seq.sv
module lpc_burst_seq
    import lpc_seq_pkg::*;
#(
    parameter int unsigned QDEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        eng_req,
    output logic        eng_write,
    output logic [15:0] eng_addr,
    output logic [7:0]  eng_wdata,
    input  logic        eng_done,
    input  logic        eng_err,
    input  logic [7:0]  eng_rdata,
    output logic        irq
);
    burst_cfg_t cfg_r;
    logic       irq_en, irq_st;
    logic       start, busy, seq_idle, burst_fixed, finished, end_evt;
    logic       wq_pop, rq_push, rq_pop, wq_push, rq_flush;
    logic [7:0] rq_dout;
    logic       wq_empty, wq_full, rq_empty, rq_full;

    assign start    = bus_we && (bus_addr == OFF_START) && bus_wdata[0];
    assign wq_push  = bus_we && (bus_addr == OFF_WDAT);
    assign rq_pop   = bus_re && (bus_addr == OFF_RDAT);
    assign rq_flush = start && !busy;
    assign seq_idle = !busy;
    assign irq      = irq_en && irq_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r  <= '0;
            irq_en <= 1'b0;
            irq_st <= 1'b0;
        end else begin
            if (bus_we) begin
                unique case (bus_addr)
                    OFF_LEN:  cfg_r.len  <= bus_wdata[7:0];
                    OFF_ADDR: cfg_r.addr <= bus_wdata[15:0];
                    OFF_CMD: begin
                        cfg_r.write <= bus_wdata[CMD_WR_BIT];
                        cfg_r.fixed <= bus_wdata[CMD_FIX_BIT];
                    end
                    OFF_IRQ:  irq_en <= bus_wdata[0];
                    default: ;
                endcase
            end
            if (end_evt)
                irq_st <= 1'b1;
            else if (bus_we && (bus_addr == OFF_IRQ) && bus_wdata[1])
                irq_st <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_STAT: bus_rdata = {30'd0, finished, seq_idle};
            OFF_IRQ:  bus_rdata = {30'd0, irq_st, irq_en};
            OFF_LEN:  bus_rdata = {24'd0, cfg_r.len};
            OFF_CMD:  bus_rdata = {28'd0, cfg_r.fixed, 2'd0, cfg_r.write};
            OFF_ADDR: bus_rdata = {16'd0, cfg_r.addr};
            OFF_RDAT: bus_rdata = {24'd0, rq_dout};
            default:  bus_rdata = '0;
        endcase
    end

    burst_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg_r),
        .eng_done(eng_done), .eng_err(eng_err),
        .eng_req(eng_req), .eng_write(eng_write), .eng_addr(eng_addr),
        .busy(busy), .fixed_mode(burst_fixed), .finished(finished),
        .end_evt(end_evt), .wq_pop(wq_pop), .rq_push(rq_push)
    );

    byte_queue #(.DEPTH(QDEPTH), .WIDTH(BYTE_W)) u_wq (
        .clk(clk), .rst(rst), .flush(1'b0),
        .push(wq_push), .din(bus_wdata[7:0]),
        .pop(wq_pop), .dout(eng_wdata), .empty(wq_empty), .full(wq_full)
    );

    byte_queue #(.DEPTH(QDEPTH), .WIDTH(BYTE_W)) u_rq (
        .clk(clk), .rst(rst), .flush(rq_flush),
        .push(rq_push), .din(eng_rdata),
        .pop(rq_pop), .dout(rq_dout), .empty(rq_empty), .full(rq_full)
    );
endmodule

// File: rtl/lpc_burst_seq_chk.sv
module lpc_burst_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        eng_req,
    input logic        eng_done,
    input logic        eng_err,
    input logic [15:0] eng_addr,
    input logic        fixed_mode,
    input logic        seq_idle
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!eng_req && seq_idle));

    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_done && !eng_err) |=> (eng_req && $stable(eng_addr)));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_done && !eng_err && !fixed_mode) |=>
        (!eng_req || eng_addr == $past(eng_addr) + 16'd1));

    a_r4_addr_fixed: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_done && !eng_err && fixed_mode) |=>
        (!eng_req || eng_addr == $past(eng_addr)));

    a_r6_busy_flag: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> !seq_idle);

    a_r8_err_abort: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_err) |=> !eng_req);
endmodule

bind lpc_burst_seq lpc_burst_seq_chk u_chk (
    .clk(clk), .rst(rst), .eng_req(eng_req), .eng_done(eng_done),
    .eng_err(eng_err), .eng_addr(eng_addr), .fixed_mode(burst_fixed),
    .seq_idle(seq_idle)
);

// File: tb/sim_lpc_burst_seq.sv
`timescale 1ns/1ps
module sim_lpc_burst_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_req, eng_write, irq;
    logic [15:0] eng_addr;
    logic [7:0]  eng_wdata;
    logic        eng_done = 1'b0, eng_err = 1'b0;
    logic [7:0]  eng_rdata = '0;

    int checks = 0, fails = 0;
    int nlog = 0, dly = 0, err_at = 99, wcnt = 0;
    logic [15:0] log_addr [32];
    logic [7:0]  log_data [32];

    always #2.5 clk = ~clk;

    lpc_burst_seq u0 (.*);

    // engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_done || eng_err) begin
                eng_done = 1'b0; eng_err = 1'b0; wcnt = 0;
            end else if (eng_req) begin
                if (wcnt >= dly) begin
                    if (nlog == err_at) eng_err = 1'b1;
                    else begin
                        log_addr[nlog] = eng_addr;
                        log_data[nlog] = eng_wdata;
                        eng_rdata = 8'hA0 + 8'(nlog);
                        nlog++;
                        eng_done = 1'b1;
                    end
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_re = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(8'h04, s);
            if (s[0]) break;
        end
    endtask

    task automatic run(input logic [7:0] len, input logic [31:0] cmd, input logic [15:0] a);
        nlog = 0;
        wr(8'h10, {24'd0, len}); wr(8'h14, cmd); wr(8'h20, {16'd0, a});
        wr(8'h00, 32'd1);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rd(8'h04, s);
        chk("R1 status", s[1:0], 2'b01);
        chk("R1 eng_req", eng_req, 1'b0);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_write_inc();
        logic [31:0] s;
        wr(8'h24, 32'h11); wr(8'h24, 32'h22); wr(8'h24, 32'h33);
        run(8'd3, 32'h1, 16'h02F8);
        chk("R2 count", nlog, 3);
        chk("R2 data0", log_data[0], 8'h11);
        chk("R2 data1", log_data[1], 8'h22);
        chk("R2 data2", log_data[2], 8'h33);
        chk("R3 addr0", log_addr[0], 16'h02F8);
        chk("R3 addr2", log_addr[2], 16'h02FA);
        rd(8'h04, s);
        chk("R6 finished", s[1:0], 2'b11);
    endtask

    task automatic t_read_fixed();
        logic [31:0] d;
        run(8'd4, 32'h8, 16'h00E4);
        chk("R4 count", nlog, 4);
        for (int i = 0; i < 4; i++) chk("R4 addr", log_addr[i], 16'h00E4);
        for (int i = 0; i < 4; i++) begin
            rd(8'h28, d);
            chk("R5 read byte", d, 32'hA0 + i);
        end
        rd(8'h28, d);
        chk("R5 empty read", d, 32'h0);
    endtask

    task automatic t_badlen();
        logic [31:0] s;
        run(8'd0, 32'h0, 16'h0060);
        rd(8'h04, s);
        chk("R7 len0 status", s[1:0], 2'b01);
        chk("R7 len0 requests", nlog, 0);
        run(8'd17, 32'h0, 16'h0060);
        rd(8'h04, s);
        chk("R7 len17 status", s[1:0], 2'b01);
        chk("R7 len17 requests", nlog, 0);
    endtask

    task automatic t_error();
        logic [31:0] s, d;
        err_at = 2;
        run(8'd5, 32'h0, 16'h0100);
        repeat (10) @(negedge clk);
        chk("R8 requests", nlog, 2);
        chk("R8 eng_req", eng_req, 1'b0);
        rd(8'h04, s);
        chk("R8 status", s[1:0], 2'b01);
        rd(8'h28, d); chk("R8 kept byte0", d, 32'hA0);
        rd(8'h28, d); chk("R8 kept byte1", d, 32'hA1);
        rd(8'h28, d); chk("R8 queue empty", d, 32'h0);
        err_at = 99;
    endtask

    task automatic t_busy_start();
        dly = 4; nlog = 0;
        wr(8'h10, 32'd4); wr(8'h14, 32'h0); wr(8'h20, 32'h0200);
        wr(8'h00, 32'd1);
        wr(8'h10, 32'd8);
        chk("R9 still busy", eng_req, 1'b1);
        wr(8'h00, 32'd1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R9 request count", nlog, 4);
        chk("R9 last addr", log_addr[3], 16'h0203);
        dly = 0;
    endtask

    task automatic t_irq();
        logic [31:0] s;
        chk("R10 irq disabled", irq, 1'b0);
        wr(8'h08, 32'h2);
        rd(8'h08, s);
        chk("R10 w1c clear", s[1], 1'b0);
        wr(8'h08, 32'h1);
        chk("R10 no pending", irq, 1'b0);
        run(8'd1, 32'h0, 16'h0070);
        @(negedge clk);
        chk("R10 irq raised", irq, 1'b1);
        wr(8'h08, 32'h3);
        @(negedge clk);
        chk("R10 irq cleared", irq, 1'b0);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 17; i++) wr(8'h24, 32'h40 + i);
        run(8'd16, 32'h1, 16'h0300);
        chk("R11 count", nlog, 16);
        chk("R11 first", log_data[0], 8'h40);
        chk("R11 sixteenth", log_data[15], 8'h4F);
        run(8'd1, 32'h1, 16'h0300);
        chk("R11 dropped byte", log_data[0], 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_inc();
        t_read_fixed();
        t_badlen();
        t_error();
        t_busy_start();
        t_irq();
        t_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule